// File: doc/BRIEF.md
# Conversion Result Magnitude Monitor with Accumulator

This block sits behind a current-sensing ADC and post-processes its stream of signed 16-bit results. Every result is reduced to its magnitude and compared with a programmable threshold. The comparison can raise an interrupt directly. It can also feed an exceedance counter that counts results above the threshold, or results below it, and raises the interrupt once a programmed count is reached. A separate conversion counter can raise the interrupt after a set number of results. A 32-bit accumulator adds or subtracts every result, and its running value is on a port.

The block is meant to run while the processor sleeps. The interrupt line is the wake-up source, and it stays asserted until software clears the flag that caused it. Configuration is written through a simple write port. Addresses 0 to 3 hold the configuration words. Address 4 is an action register whose bits clear flags or the accumulator.

Top module: `adc_result_monitor`

## Requirements
- R1: After reset all flags, counters, the accumulator and `irq` are zero, and every mode is off.
- R2: With comparator mode 01 (control bits [1:0]), a result whose magnitude is strictly greater than the threshold (address 1) sets `thr_flag` on the clock edge that samples it. A result whose magnitude equals the threshold does not set the flag. The code -32768 has magnitude 32768, with no wrap.
- R3: With comparator mode 10, each result whose magnitude is above the threshold increments `thr_count`. `thr_flag` sets when the count reaches the limit (address 2), and the count then saturates at the limit.
- R4: With comparator mode 11, only results whose magnitude is strictly below the threshold are counted, with the same limit behaviour as R3.
- R5: With control bit 4 set, every valid result increments `conv_count`. `conv_flag` sets when the count reaches the conversion limit (address 3), and the count saturates there.
- R6: Accumulator mode is control bits [3:2]. In mode 01 each sign-extended result is added to `acc_value` and in mode 10 it is subtracted. Modes 00 and 11 leave `acc_value` unchanged.
- R7: The accumulator wraps modulo 2^32. A signed overflow sets the sticky `acc_ovf`, which stays set until action bit 2 is written.
- R8: A write to any of addresses 0 to 3 clears `thr_count` and `conv_count`. A write to address 4 clears neither counter, and no write changes `acc_value` except through action bit 3.
- R9: `irq` is the OR of `thr_flag` and `conv_flag`. Each flag stays set until software writes action bit 0 (for `thr_flag`) or action bit 1 (for `conv_flag`). A flag that is set and cleared in the same cycle ends up set.
- R10: Action bit 3 clears the accumulator. If a result arrives in the same cycle, the clear wins and that result is dropped.
- R11: With comparator mode 00, results neither change `thr_count` nor set `thr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Strobe marking a new conversion result |
| res_data | input | 16 | Signed conversion result |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Register address: 0 control, 1 threshold, 2 exceedance limit, 3 conversion limit, 4 action |
| cfg_wdata | input | 16 | Write data |
| irq | output | 1 | Interrupt, OR of the sticky flags |
| thr_flag | output | 1 | Sticky threshold or exceedance-count flag |
| conv_flag | output | 1 | Sticky conversion-count flag |
| acc_ovf | output | 1 | Sticky accumulator overflow flag |
| thr_count | output | 16 | Exceedance counter |
| conv_count | output | 16 | Conversion counter |
| acc_value | output | 32 | Accumulator value |

## Verification
A table of results is run against a threshold of 1000. It holds magnitudes just above and exactly at the threshold, with both signs, plus zero, both full-scale codes and a value just below. This separates a strict compare from a greater-or-equal compare and a magnitude compare from a signed one. The same table runs the accumulator in add mode against a running sum kept by the bench. Directed sequences then cover counting above and below the threshold up to saturation, and the conversion counter. They also cover which writes reset the counters, subtract mode and the reserved accumulator mode, a clear that collides with a result, and a long run of full-scale results that reaches the exact signed overflow point.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;

    typedef enum logic [1:0] {
        CMP_OFF    = 2'b00,
        CMP_DIRECT = 2'b01,
        CMP_ABOVE  = 2'b10,
        CMP_BELOW  = 2'b11
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ACC_OFF  = 2'b00,
        ACC_ADD  = 2'b01,
        ACC_SUB  = 2'b10,
        ACC_RSVD = 2'b11
    } acc_mode_e;

    // control word, bit 4 down to bit 0
    typedef struct packed {
        logic      conv_en;
        acc_mode_e acc_mode;
        cmp_mode_e cmp_mode;
    } ctrl_t;

    // action word, bit 3 down to bit 0
    typedef struct packed {
        logic clr_acc;
        logic clr_ovf;
        logic clr_conv;
        logic clr_thr;
    } action_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned ACT_W  = $bits(action_t);

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_THR  = 3'd1;
    localparam logic [2:0] ADR_TLIM = 3'd2;
    localparam logic [2:0] ADR_CLIM = 3'd3;
    localparam logic [2:0] ADR_ACT  = 3'd4;

endpackage

// File: rtl/adc_mon_regs.sv
module adc_mon_regs
    import adc_mon_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] thr,
    output logic [CNT_W-1:0]  tlim,
    output logic [CNT_W-1:0]  clim,
    output logic              cfg_touch,
    output action_t           act
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] thr;
        logic [CNT_W-1:0]  tlim;
        logic [CNT_W-1:0]  clim;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cfg_touch = 1'b0;
        act       = '0;
        if (we) begin
            unique case (addr)
                ADR_CTRL: begin
                    st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
                    cfg_touch = 1'b1;
                end
                ADR_THR: begin
                    st_d.thr  = wdata;
                    cfg_touch = 1'b1;
                end
                ADR_TLIM: begin
                    st_d.tlim = wdata[CNT_W-1:0];
                    cfg_touch = 1'b1;
                end
                ADR_CLIM: begin
                    st_d.clim = wdata[CNT_W-1:0];
                    cfg_touch = 1'b1;
                end
                ADR_ACT: act = action_t'(wdata[ACT_W-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;
    assign thr  = st_q.thr;
    assign tlim = st_q.tlim;
    assign clim = st_q.clim;

    // R2
    thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_THR) |=> (thr == $past(wdata)));

    // R8
    act_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_ACT) |=> $stable(ctrl));

endmodule

// File: rtl/adc_mon_cmp.sv
module adc_mon_cmp
    import adc_mon_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  cmp_mode_e         mode,
    input  logic [DATA_W-1:0] thr,
    input  logic [CNT_W-1:0]  lim,
    input  logic              touch,
    input  logic              clr,
    output logic [CNT_W-1:0]  cnt,
    output logic              flag
);

    localparam int unsigned MAG_W = DATA_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } cmp_t;

    cmp_t st_d, st_q;

    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] thr_x;
    logic             above;
    logic             below;
    logic             qual;
    logic             hit;

    always_comb begin
        thr_x = {1'b0, thr};
        if (data[DATA_W-1]) mag = '0 - {1'b1, data};
        else                mag = {1'b0, data};
        above = mag > thr_x;
        below = mag < thr_x;
        qual  = ((mode == CMP_ABOVE) && above) || ((mode == CMP_BELOW) && below);
        hit   = 1'b0;
        st_d  = st_q;
        if (valid && (mode == CMP_DIRECT) && above) hit = 1'b1;
        if (touch) begin
            st_d.cnt = '0;
        end else if (valid && qual) begin
            if (st_q.cnt < lim) st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == lim) hit = 1'b1;
        end
        st_d.flag = (st_q.flag && !clr) || hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign flag = st_q.flag;

    // R3
    thr_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(touch) |-> (st_q.cnt <= lim));

    // R8
    thr_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (st_q.cnt == '0));

    // R9
    thr_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr) |=> st_q.flag);

    // R11
    thr_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CMP_OFF && !touch) |=> $stable(st_q.cnt));

endmodule

// File: rtl/adc_mon_conv.sv
module adc_mon_conv #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             valid,
    input  logic [CNT_W-1:0] lim,
    input  logic             touch,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } conv_t;

    conv_t st_d, st_q;
    logic  hit;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (touch) begin
            st_d.cnt = '0;
        end else if (en && valid) begin
            if (st_q.cnt < lim) st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == lim) hit = 1'b1;
        end
        st_d.flag = (st_q.flag && !clr) || hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign flag = st_q.flag;

    // R5
    conv_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(touch) |-> (st_q.cnt <= lim));

    // R8
    conv_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (st_q.cnt == '0));

    // R9
    conv_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr) |=> st_q.flag);

endmodule

// File: rtl/adc_mon_acc.sv
module adc_mon_acc
    import adc_mon_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  acc_mode_e         mode,
    input  logic              clr_acc,
    input  logic              clr_ovf,
    output logic [ACC_W-1:0]  acc,
    output logic              ovf
);

    localparam int unsigned EXT_W = ACC_W - DATA_W;
    localparam int unsigned MSB   = ACC_W - 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
    } acc_t;

    acc_t st_d, st_q;

    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] dif;
    logic             ovf_add;
    logic             ovf_sub;
    logic             wrap;

    always_comb begin
        ext     = {{EXT_W{data[DATA_W-1]}}, data};
        sum     = st_q.acc + ext;
        dif     = st_q.acc - ext;
        ovf_add = (st_q.acc[MSB] == ext[MSB]) && (sum[MSB] != st_q.acc[MSB]);
        ovf_sub = (st_q.acc[MSB] != ext[MSB]) && (dif[MSB] != st_q.acc[MSB]);
        wrap    = 1'b0;
        st_d    = st_q;
        if (clr_acc) begin
            st_d.acc = '0;
        end else if (valid) begin
            unique case (mode)
                ACC_ADD: begin
                    st_d.acc = sum;
                    wrap     = ovf_add;
                end
                ACC_SUB: begin
                    st_d.acc = dif;
                    wrap     = ovf_sub;
                end
                default: ;
            endcase
        end
        st_d.ovf = (st_q.ovf && !clr_ovf) || wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = st_q.acc;
    assign ovf = st_q.ovf;

    // R6
    acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clr_acc) |=> $stable(st_q.acc));

    // R6
    acc_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_acc && (mode == ACC_RSVD || mode == ACC_OFF)) |=> $stable(st_q.acc));

    // R7
    acc_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !clr_ovf) |=> st_q.ovf);

    // R10
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_acc |=> (st_q.acc == '0));

endmodule

// File: rtl/adc_result_monitor.sv
module adc_result_monitor
    import adc_mon_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              irq,
    output logic              thr_flag,
    output logic              conv_flag,
    output logic              acc_ovf,
    output logic [CNT_W-1:0]  thr_count,
    output logic [CNT_W-1:0]  conv_count,
    output logic [ACC_W-1:0]  acc_value
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] thr;
    logic [CNT_W-1:0]  tlim;
    logic [CNT_W-1:0]  clim;
    logic              cfg_touch;
    action_t           act;

    adc_mon_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .ctrl      (ctrl),
        .thr       (thr),
        .tlim      (tlim),
        .clim      (clim),
        .cfg_touch (cfg_touch),
        .act       (act)
    );

    adc_mon_cmp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (res_valid),
        .data  (res_data),
        .mode  (ctrl.cmp_mode),
        .thr   (thr),
        .lim   (tlim),
        .touch (cfg_touch),
        .clr   (act.clr_thr),
        .cnt   (thr_count),
        .flag  (thr_flag)
    );

    adc_mon_conv #(.CNT_W(CNT_W)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl.conv_en),
        .valid (res_valid),
        .lim   (clim),
        .touch (cfg_touch),
        .clr   (act.clr_conv),
        .cnt   (conv_count),
        .flag  (conv_flag)
    );

    adc_mon_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (res_valid),
        .data    (res_data),
        .mode    (ctrl.acc_mode),
        .clr_acc (act.clr_acc),
        .clr_ovf (act.clr_ovf),
        .acc     (acc_value),
        .ovf     (acc_ovf)
    );

    assign irq = thr_flag || conv_flag;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq && acc_value == '0 && !acc_ovf));

endmodule

// File: tb/adc_result_monitor_test.sv
module adc_result_monitor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        irq, thr_flag, conv_flag, acc_ovf;
    logic [15:0] thr_count, conv_count;
    logic [31:0] acc_value;

    int total = 0;
    int bad = 0;
    logic [31:0] acc_exp;

    always #5 clk = ~clk;

    adc_result_monitor uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .irq(irq), .thr_flag(thr_flag), .conv_flag(conv_flag), .acc_ovf(acc_ovf),
        .thr_count(thr_count), .conv_count(conv_count), .acc_value(acc_value)
    );

    // {result, expected thr_flag} for direct mode with threshold 1000
    localparam logic [16:0] VEC [8] = '{
        {16'd1001, 1'b1},
        {16'd1000, 1'b0},
        {16'hFC17, 1'b1},
        {16'hFC18, 1'b0},
        {16'h0000, 1'b0},
        {16'h7FFF, 1'b1},
        {16'h8000, 1'b1},
        {16'hFC19, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] d);
        @(negedge clk);
        res_valid = 1'b1; res_data = d;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 flags", {29'd0, thr_flag, conv_flag, acc_ovf}, 32'd0);
        chk("R1 counts", {thr_count, conv_count}, 32'd0);
        chk("R1 acc", acc_value, 32'd0);

        // R2 + R6 table: direct compare, accumulator adding
        wr(3'd1, 16'd1000);
        wr(3'd0, 16'b0_01_01);
        acc_exp = '0;
        for (int i = 0; i < 8; i++) begin
            send(VEC[i][16:1]);
            acc_exp = acc_exp + {{16{VEC[i][16]}}, VEC[i][16:1]};
            chk("R2 direct flag", {31'd0, thr_flag}, {31'd0, VEC[i][0]});
            chk("R9 irq follows flag", {31'd0, irq}, {31'd0, VEC[i][0]});
            chk("R6 add sum", acc_value, acc_exp);
            wr(3'd4, 16'h0001);
            chk("R9 flag cleared", {31'd0, thr_flag}, 32'd0);
        end

        // R2 most negative code against threshold 32767
        wr(3'd1, 16'h7FFF);
        send(16'h8000);
        chk("R2 -32768 exceeds 32767", {31'd0, thr_flag}, 32'd1);
        wr(3'd4, 16'h0001);

        // R3 count above, threshold 100, limit 3
        wr(3'd0, 16'b0_00_10);
        wr(3'd1, 16'd100);
        wr(3'd2, 16'd3);
        send(16'd50); send(16'hFF38); send(16'd100); send(16'd150);
        chk("R3 count two", {16'd0, thr_count}, 32'd2);
        chk("R3 no flag yet", {31'd0, thr_flag}, 32'd0);
        send(16'hFF9B);
        chk("R3 count at limit", {16'd0, thr_count}, 32'd3);
        chk("R3 flag at limit", {31'd0, thr_flag}, 32'd1);
        send(16'd500);
        chk("R3 saturates", {16'd0, thr_count}, 32'd3);

        // R8 action write keeps counter, config write clears it
        wr(3'd4, 16'h0001);
        chk("R8 action keeps count", {16'd0, thr_count}, 32'd3);
        chk("R9 irq low after clear", {31'd0, irq}, 32'd0);
        wr(3'd1, 16'd100);
        chk("R8 config write clears count", {16'd0, thr_count}, 32'd0);

        // R4 count below, threshold 100, limit 2
        wr(3'd0, 16'b0_00_11);
        wr(3'd2, 16'd2);
        send(16'd99);
        chk("R4 one below", {16'd0, thr_count}, 32'd1);
        send(16'd100);
        chk("R4 equal not counted", {16'd0, thr_count}, 32'd1);
        send(16'hFFFB);
        chk("R4 limit flag", {15'd0, thr_flag, thr_count}, 32'h0001_0002);
        wr(3'd4, 16'h0001);

        // R11 comparator off
        wr(3'd0, 16'b0_00_00);
        send(16'd5000); send(16'd5000); send(16'hEC78);
        chk("R11 off no count", {15'd0, thr_flag, thr_count}, 32'd0);

        // R5 conversion counter, limit 4
        wr(3'd3, 16'd4);
        wr(3'd0, 16'b1_00_00);
        send(16'd1); send(16'd2); send(16'd3);
        chk("R5 three counted", {15'd0, conv_flag, conv_count}, 32'h0000_0003);
        send(16'd4);
        chk("R5 flag at limit", {15'd0, conv_flag, conv_count}, 32'h0001_0004);
        chk("R9 irq from conv", {31'd0, irq}, 32'd1);
        send(16'd5);
        chk("R5 saturates", {16'd0, conv_count}, 32'd4);
        wr(3'd4, 16'h0002);
        chk("R9 conv flag cleared", {30'd0, conv_flag, irq}, 32'd0);

        // R6 subtract and reserved mode, R10 clear
        wr(3'd4, 16'h0008);
        chk("R10 acc cleared", acc_value, 32'd0);
        wr(3'd0, 16'b0_10_00);
        send(16'd10); send(16'hFFFD);
        chk("R6 subtract", acc_value, 32'hFFFF_FFF9);
        wr(3'd0, 16'b0_11_00);
        send(16'd100);
        chk("R6 reserved holds", acc_value, 32'hFFFF_FFF9);
        wr(3'd0, 16'b0_00_00);
        send(16'd100);
        chk("R6 off holds", acc_value, 32'hFFFF_FFF9);

        // R10 clear colliding with a result
        wr(3'd0, 16'b0_01_00);
        send(16'd7);
        chk("R6 add after clear base", acc_value, 32'hFFFF_FFF9 + 32'd7);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 16'h0008;
        res_valid = 1'b1; res_data = 16'd500;
        @(negedge clk);
        cfg_we = 1'b0; res_valid = 1'b0;
        chk("R10 clear wins", acc_value, 32'd0);

        // R7 overflow by subtracting -32768 repeatedly
        wr(3'd0, 16'b0_10_00);
        @(negedge clk);
        res_valid = 1'b1; res_data = 16'h8000;
        repeat (65535) @(negedge clk);
        res_valid = 1'b0;
        chk("R7 just below", acc_value, 32'h7FFF_8000);
        chk("R7 no ovf yet", {31'd0, acc_ovf}, 32'd0);
        send(16'h8000);
        chk("R7 wraps", acc_value, 32'h8000_0000);
        chk("R7 ovf set", {31'd0, acc_ovf}, 32'd1);
        wr(3'd0, 16'b0_01_00);
        send(16'd1);
        chk("R7 ovf sticky", {31'd0, acc_ovf}, 32'd1);
        chk("R7 acc after", acc_value, 32'h8000_0001);
        wr(3'd4, 16'h0004);
        chk("R7 ovf cleared", {31'd0, acc_ovf}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule